// File: doc/BRIEF.md
# Configurable Integer Divider

This block divides an N-bit numerator by a D-bit denominator. It returns an N-bit quotient and a D-bit remainder. Each operand is set on its own as unsigned or two's-complement signed. A parameter chooses the remainder convention. In truncating mode the quotient rounds toward zero and the remainder follows the sign of the numerator. In non-negative mode the remainder is never below zero and never reaches the magnitude of the divisor.

Internally the block strips the operand signs, runs an N-step restoring division on the magnitudes, and then puts the signs back according to the selected convention. A latency parameter spreads from zero to N register stages evenly over the N division steps. With zero stages the block is purely combinational. The registers share a clock enable and an asynchronous clear. A zero denominator gives a fixed, harmless result, so no X values reach downstream logic.

Top module: `int_divider`

## Requirements
- R1: With both operands unsigned, quotient = floor(numer / denom) and remain = numer mod denom.
- R2: Each operand is read as signed (two's complement) or unsigned, according to its own parameter. A signed numerator may be paired with an unsigned denominator.
- R3: In truncating mode (REM_MODE = REM_TRUNC) the quotient rounds toward zero, and the remainder is zero or has the numerator's sign. Examples: -3/2 gives -1 rem -1, and -3/-2 gives 1 rem -1.
- R4: In non-negative mode (REM_MODE = REM_NONNEG) numer = quotient*denom + remain, with 0 <= remain < |denom|. Examples: -3/2 gives -2 rem 1, and -3/-2 gives 2 rem 1. For a non-negative numerator both modes give the same result, for example 3/-2 gives -1 rem 1.
- R5: The quotient is delivered modulo 2^N and the remainder modulo 2^D. The most negative numerator divided by -1 therefore returns the most negative numerator.
- R6: With LATENCY = 0 the outputs follow the inputs combinationally. With LATENCY = L > 0, an operand pair captured at a rising clock edge with clk_en high appears on the outputs after exactly L enabled edges. L must be between 0 and N.
- R7: While clk_en is low, every stage holds its contents, so the outputs stay unchanged and the order of results is kept across stalls.
- R8: A high aclr forces every stage register to zero at once, without waiting for a clock edge. The outputs then read quotient 0 and remainder 0.
- R9: When denom is zero, quotient is all ones and remain is the numerator's value modulo 2^D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stage registers |
| aclr | input | 1 | Asynchronous clear of all stage registers, active high |
| clk_en | input | 1 | Advances all stages when high |
| numer | input | NUM_W | Dividend |
| denom | input | DEN_W | Divisor |
| quotient | output | NUM_W | Quotient |
| remain | output | DEN_W | Remainder |

## Verification
A corrupted partial remainder or quotient bit inside a stage appears on the ports after the remaining stages have passed it along, which is within LATENCY enabled cycles. It is seen as a quotient and remainder pair that breaks numer = q*d + r, or as a remainder with the wrong sign for the selected mode. A stage that advances during a stall, or a clear that waits for a clock edge, changes the outputs in that same cycle. A lost or duplicated stage shifts every later result by one position in the stream. Because operands are streamed back to back, that shift shows up on the very next compared result.

// File: rtl/div_pkg.sv
package div_pkg;

   typedef enum logic {
      REM_TRUNC  = 1'b0,
      REM_NONNEG = 1'b1
   } rem_mode_e;

   // True when a register sits after division step 'step' of 'steps',
   // spreading 'lat' registers as evenly as integer division allows.
   function automatic bit stage_registered(input int step, input int lat, input int steps);
      return (((step + 1) * lat) / steps) != ((step * lat) / steps);
   endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
   parameter int NUM_W      = 8,
   parameter int DEN_W      = 6,
   parameter bit NUM_SIGNED = 1'b1,
   parameter bit DEN_SIGNED = 1'b1
) (
   input  logic [NUM_W-1:0] numer,
   input  logic [DEN_W-1:0] denom,
   output logic [NUM_W-1:0] n_mag,
   output logic [DEN_W-1:0] d_mag,
   output logic             n_neg,
   output logic             d_neg,
   output logic             d_zero
);

   generate
      if (NUM_SIGNED) begin : g_num_signed
         assign n_neg = numer[NUM_W-1];
      end else begin : g_num_unsigned
         assign n_neg = 1'b0;
      end
      if (DEN_SIGNED) begin : g_den_signed
         assign d_neg = denom[DEN_W-1];
      end else begin : g_den_unsigned
         assign d_neg = 1'b0;
      end
   endgenerate

   // Magnitude of the most negative value fits in the unsigned width.
   assign n_mag  = n_neg ? (~numer + 1'b1) : numer;
   assign d_mag  = d_neg ? (~denom + 1'b1) : denom;
   assign d_zero = (denom == '0);

endmodule

// File: rtl/div_stage_chain.sv
module div_stage_chain import div_pkg::*; #(
   parameter int NUM_W   = 8,
   parameter int DEN_W   = 6,
   parameter int LATENCY = 2
) (
   input  logic             clk,
   input  logic             aclr,
   input  logic             clk_en,
   input  logic [NUM_W-1:0] in_n_mag,
   input  logic [DEN_W-1:0] in_d_mag,
   input  logic             in_n_neg,
   input  logic             in_d_neg,
   input  logic             in_d_zero,
   output logic [NUM_W-1:0] out_q,
   output logic [DEN_W-1:0] out_r,
   output logic [DEN_W-1:0] out_d_mag,
   output logic             out_n_neg,
   output logic             out_d_neg,
   output logic             out_d_zero
);

   typedef struct packed {
      logic [DEN_W-1:0] rem;
      logic [NUM_W-1:0] quo;
      logic [NUM_W-1:0] num;
      logic [DEN_W-1:0] dmag;
      logic             nneg;
      logic             dneg;
      logic             dzero;
   } stage_t;

   // One restoring step: bring in the next dividend bit, subtract if it fits.
   function automatic stage_t advance(input stage_t s);
      stage_t       o;
      logic [DEN_W:0] trial;
      o     = s;
      trial = {s.rem, s.num[NUM_W-1]};
      o.num = {s.num[NUM_W-2:0], 1'b0};
      if (trial >= {1'b0, s.dmag}) begin
         o.rem = trial[DEN_W-1:0] - s.dmag;
         o.quo = {s.quo[NUM_W-2:0], 1'b1};
      end else begin
         o.rem = trial[DEN_W-1:0];
         o.quo = {s.quo[NUM_W-2:0], 1'b0};
      end
      return o;
   endfunction

   stage_t st [0:NUM_W];

   assign st[0] = '{rem: '0, quo: '0, num: in_n_mag, dmag: in_d_mag,
                    nneg: in_n_neg, dneg: in_d_neg, dzero: in_d_zero};

   generate
      for (genvar i = 0; i < NUM_W; i++) begin : g_step
         stage_t nxt;
         always_comb nxt = advance(st[i]);
         if (stage_registered(i, LATENCY, NUM_W)) begin : g_reg
            stage_t held;
            always_ff @(posedge clk or posedge aclr) begin
               if (aclr)        held <= '0;
               else if (clk_en) held <= nxt;
            end
            assign st[i+1] = held;
         end else begin : g_wire
            assign st[i+1] = nxt;
         end
      end
   endgenerate

   assign out_q      = st[NUM_W].quo;
   assign out_r      = st[NUM_W].rem;
   assign out_d_mag  = st[NUM_W].dmag;
   assign out_n_neg  = st[NUM_W].nneg;
   assign out_d_neg  = st[NUM_W].dneg;
   assign out_d_zero = st[NUM_W].dzero;

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix import div_pkg::*; #(
   parameter int        NUM_W    = 8,
   parameter int        DEN_W    = 6,
   parameter rem_mode_e REM_MODE = REM_NONNEG
) (
   input  logic [NUM_W-1:0] q_mag,
   input  logic [DEN_W-1:0] r_mag,
   input  logic [DEN_W-1:0] d_mag,
   input  logic             n_neg,
   input  logic             d_neg,
   input  logic             d_zero,
   output logic [NUM_W-1:0] quotient,
   output logic [DEN_W-1:0] remain
);

   logic [NUM_W-1:0] q_adj;
   logic [DEN_W-1:0] r_adj;
   logic             r_neg;

   generate
      if (REM_MODE == REM_NONNEG) begin : g_nonneg
         // Negative dividend with a leftover: step the magnitude quotient
         // one further from zero and fold the remainder into the divisor.
         logic round_away;
         assign round_away = n_neg && (r_mag != '0);
         assign q_adj      = round_away ? q_mag + 1'b1 : q_mag;
         assign r_adj      = round_away ? d_mag - r_mag : r_mag;
         assign r_neg      = 1'b0;
      end else begin : g_trunc
         assign q_adj = q_mag;
         assign r_adj = r_mag;
         assign r_neg = n_neg;
      end
   endgenerate

   always_comb begin
      if (d_zero) begin
         quotient = '1;
         remain   = n_neg ? (~r_mag + 1'b1) : r_mag;
      end else begin
         quotient = (n_neg ^ d_neg) ? (~q_adj + 1'b1) : q_adj;
         remain   = r_neg ? (~r_adj + 1'b1) : r_adj;
      end
   end

endmodule

// File: rtl/int_divider.sv
module int_divider import div_pkg::*; #(
   parameter int        NUM_W      = 8,
   parameter int        DEN_W      = 6,
   parameter bit        NUM_SIGNED = 1'b1,
   parameter bit        DEN_SIGNED = 1'b1,
   parameter rem_mode_e REM_MODE   = REM_NONNEG,
   parameter int        LATENCY    = 2
) (
   input  logic             clk,
   input  logic             aclr,
   input  logic             clk_en,
   input  logic [NUM_W-1:0] numer,
   input  logic [DEN_W-1:0] denom,
   output logic [NUM_W-1:0] quotient,
   output logic [DEN_W-1:0] remain
);

   generate
      if (NUM_W < 2 || DEN_W < 2) begin : g_bad_width
         $error("int_divider: operand widths must be at least 2");
      end
      if (LATENCY < 0 || LATENCY > NUM_W) begin : g_bad_latency
         $error("int_divider: LATENCY must lie in 0..NUM_W");
      end
   endgenerate

   logic [NUM_W-1:0] pre_n_mag;
   logic [DEN_W-1:0] pre_d_mag;
   logic             pre_n_neg, pre_d_neg, pre_d_zero;

   logic [NUM_W-1:0] fin_q;
   logic [DEN_W-1:0] fin_r;
   logic [DEN_W-1:0] fin_d_mag;
   logic             fin_n_neg, fin_d_neg, fin_d_zero;

   div_operand_prep #(
      .NUM_W(NUM_W), .DEN_W(DEN_W),
      .NUM_SIGNED(NUM_SIGNED), .DEN_SIGNED(DEN_SIGNED)
   ) u_prep (
      .numer(numer), .denom(denom),
      .n_mag(pre_n_mag), .d_mag(pre_d_mag),
      .n_neg(pre_n_neg), .d_neg(pre_d_neg), .d_zero(pre_d_zero)
   );

   div_stage_chain #(
      .NUM_W(NUM_W), .DEN_W(DEN_W), .LATENCY(LATENCY)
   ) u_chain (
      .clk(clk), .aclr(aclr), .clk_en(clk_en),
      .in_n_mag(pre_n_mag), .in_d_mag(pre_d_mag),
      .in_n_neg(pre_n_neg), .in_d_neg(pre_d_neg), .in_d_zero(pre_d_zero),
      .out_q(fin_q), .out_r(fin_r), .out_d_mag(fin_d_mag),
      .out_n_neg(fin_n_neg), .out_d_neg(fin_d_neg), .out_d_zero(fin_d_zero)
   );

   div_result_fix #(
      .NUM_W(NUM_W), .DEN_W(DEN_W), .REM_MODE(REM_MODE)
   ) u_fix (
      .q_mag(fin_q), .r_mag(fin_r), .d_mag(fin_d_mag),
      .n_neg(fin_n_neg), .d_neg(fin_d_neg), .d_zero(fin_d_zero),
      .quotient(quotient), .remain(remain)
   );

endmodule

// File: rtl/div_checker.sv
module div_checker import div_pkg::*; #(
   parameter int        NUM_W      = 8,
   parameter int        DEN_W      = 6,
   parameter bit        DEN_SIGNED = 1'b1,
   parameter rem_mode_e REM_MODE   = REM_NONNEG,
   parameter int        LATENCY    = 2
) (
   input logic             clk,
   input logic             aclr,
   input logic             clk_en,
   input logic [NUM_W-1:0] quotient,
   input logic [DEN_W-1:0] remain,
   input logic             fin_n_neg,
   input logic             fin_d_zero
);

   // R9
   div_zero_chk: assert property (@(posedge clk) disable iff (aclr)
      fin_d_zero |-> (quotient == '1));

   generate
      if (LATENCY > 0) begin : g_seq
         // R8
         always @(negedge clk) begin
            if (aclr) begin
               clear_out_chk: assert (quotient == '0 && remain == '0);
            end
         end
         // R7
         stall_hold_chk: assert property (@(posedge clk) disable iff (aclr)
            !clk_en |=> ($stable(quotient) && $stable(remain)));
      end

      if (DEN_SIGNED && REM_MODE == REM_NONNEG) begin : g_nonneg_sign
         // R4
         rem_nonneg_chk: assert property (@(posedge clk) disable iff (aclr)
            !fin_d_zero |-> !remain[DEN_W-1]);
      end

      if (DEN_SIGNED && REM_MODE == REM_TRUNC) begin : g_trunc_sign
         // R3
         rem_pos_num_chk: assert property (@(posedge clk) disable iff (aclr)
            (!fin_d_zero && !fin_n_neg) |-> !remain[DEN_W-1]);
         // R3
         rem_neg_num_chk: assert property (@(posedge clk) disable iff (aclr)
            (!fin_d_zero && fin_n_neg) |-> (remain == '0 || remain[DEN_W-1]));
      end
   endgenerate

endmodule

bind int_divider div_checker #(
   .NUM_W(NUM_W), .DEN_W(DEN_W), .DEN_SIGNED(DEN_SIGNED),
   .REM_MODE(REM_MODE), .LATENCY(LATENCY)
) u_chk (
   .clk(clk), .aclr(aclr), .clk_en(clk_en),
   .quotient(quotient), .remain(remain),
   .fin_n_neg(fin_n_neg), .fin_d_zero(fin_d_zero)
);

// File: tb/int_divider_test.sv
module int_divider_test;
   import div_pkg::*;

   localparam int NW = 6;
   localparam int DW = 4;
   localparam int NMOD = 1 << NW;
   localparam int DMOD = 1 << DW;
   localparam int SWEEP = NMOD * DMOD;
   localparam int RAND_CYC = 400;
   localparam int HIST = SWEEP + RAND_CYC + 8;

   logic clk = 1'b0;
   logic aclr = 1'b1;
   logic clk_en = 1'b0;
   logic [NW-1:0] numer = '0;
   logic [DW-1:0] denom = '0;

   logic [NW-1:0] q_a, q_t, q_u, q_m;
   logic [DW-1:0] r_a, r_t, r_u, r_m;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   // signed / signed, non-negative remainder, 3 stages
   int_divider #(.NUM_W(NW), .DEN_W(DW), .NUM_SIGNED(1'b1), .DEN_SIGNED(1'b1),
                 .REM_MODE(REM_NONNEG), .LATENCY(3)) uut (
      .clk(clk), .aclr(aclr), .clk_en(clk_en), .numer(numer), .denom(denom),
      .quotient(q_a), .remain(r_a));
   // signed / signed, truncating, combinational
   int_divider #(.NUM_W(NW), .DEN_W(DW), .NUM_SIGNED(1'b1), .DEN_SIGNED(1'b1),
                 .REM_MODE(REM_TRUNC), .LATENCY(0)) u_trunc (
      .clk(clk), .aclr(aclr), .clk_en(clk_en), .numer(numer), .denom(denom),
      .quotient(q_t), .remain(r_t));
   // unsigned / unsigned, full latency
   int_divider #(.NUM_W(NW), .DEN_W(DW), .NUM_SIGNED(1'b0), .DEN_SIGNED(1'b0),
                 .REM_MODE(REM_NONNEG), .LATENCY(NW)) u_uns (
      .clk(clk), .aclr(aclr), .clk_en(clk_en), .numer(numer), .denom(denom),
      .quotient(q_u), .remain(r_u));
   // signed numerator / unsigned denominator, truncating, 1 stage
   int_divider #(.NUM_W(NW), .DEN_W(DW), .NUM_SIGNED(1'b1), .DEN_SIGNED(1'b0),
                 .REM_MODE(REM_TRUNC), .LATENCY(1)) u_mix (
      .clk(clk), .aclr(aclr), .clk_en(clk_en), .numer(numer), .denom(denom),
      .quotient(q_m), .remain(r_m));

   // Arithmetic reference: SV '/' and '%' truncate toward zero.
   function automatic void model(input int nv, input int dv, input bit ns, input bit ds,
                                 input bit nonneg, output int q, output int r);
      int n, d;
      n = (ns && nv >= NMOD/2) ? nv - NMOD : nv;
      d = (ds && dv >= DMOD/2) ? dv - DMOD : dv;
      if (d == 0) begin
         q = NMOD - 1;
         r = nv % DMOD;
      end else begin
         q = n / d;
         r = n % d;
         if (nonneg && r < 0) begin
            if (d > 0) begin q = q - 1; r = r + d; end
            else       begin q = q + 1; r = r - d; end
         end
         q = q & (NMOD - 1);
         r = r & (DMOD - 1);
      end
   endfunction

   function automatic string tag(input int nv, input int dv, input string base);
      if (dv == 0) return {base, " R9"};
      if (nv == NMOD/2 && dv == DMOD - 1) return {base, " R5"};
      return base;
   endfunction

   task automatic chk(input string who, input string req, input int aq, input int eq,
                      input int ar, input int er);
      n_checks++;
      if (aq != eq || ar != er) begin
         n_errors++;
         $display("FAIL %s [%s]: quotient=%0d remain=%0d expected quotient=%0d remain=%0d",
                  who, req, aq, ar, eq, er);
      end
   endtask

   int hn [0:HIST-1];
   int hd [0:HIST-1];

   initial begin
      int nacc, cur_n, cur_d, eq, er;
      bit prev_en;
      string st;
      nacc = 0; prev_en = 1'b0; cur_n = 0; cur_d = 0;

      // Reset state: cleared stages give zero results (R8)
      repeat (2) @(negedge clk);
      #1;
      chk("uut",   "R8 reset", int'(q_a), 0, int'(r_a), 0);
      chk("u_uns", "R8 reset", int'(q_u), 0, int'(r_u), 0);
      chk("u_mix", "R8 reset", int'(q_m), 0, int'(r_m), 0);
      aclr = 1'b0;

      for (int k = 0; k < SWEEP + RAND_CYC; k++) begin
         @(negedge clk);
         if (prev_en) begin
            hn[nacc] = cur_n; hd[nacc] = cur_d; nacc++;
         end
         if (k < SWEEP) begin
            cur_n = k / DMOD; cur_d = k % DMOD; clk_en = 1'b1;
         end else begin
            cur_n = int'($urandom_range(NMOD - 1, 0));
            cur_d = int'($urandom_range(DMOD - 1, 0));
            clk_en = ($urandom_range(2, 0) != 0);
         end
         numer = NW'(cur_n); denom = DW'(cur_d);
         prev_en = clk_en;
         st = (k >= SWEEP && !clk_en) ? " R7" : "";
         #1;
         // combinational truncating instance (R3, R6 at L=0)
         model(cur_n, cur_d, 1'b1, 1'b1, 1'b0, eq, er);
         chk("u_trunc", tag(cur_n, cur_d, "R3 R6"), int'(q_t), eq, int'(r_t), er);
         if (nacc >= 3) begin
            model(hn[nacc-3], hd[nacc-3], 1'b1, 1'b1, 1'b1, eq, er);
            chk("uut", tag(hn[nacc-3], hd[nacc-3], {"R4 R6", st}), int'(q_a), eq, int'(r_a), er);
         end
         if (nacc >= NW) begin
            model(hn[nacc-NW], hd[nacc-NW], 1'b0, 1'b0, 1'b1, eq, er);
            chk("u_uns", tag(hn[nacc-NW], hd[nacc-NW], {"R1 R6", st}), int'(q_u), eq, int'(r_u), er);
         end
         if (nacc >= 1) begin
            model(hn[nacc-1], hd[nacc-1], 1'b1, 1'b0, 1'b0, eq, er);
            chk("u_mix", tag(hn[nacc-1], hd[nacc-1], {"R2 R3", st}), int'(q_m), eq, int'(r_m), er);
         end
      end

      // Asynchronous clear between edges (R8)
      @(negedge clk);
      clk_en = 1'b1; numer = 6'd45; denom = 4'd3;
      repeat (NW + 1) @(negedge clk);
      #1;
      model(45, 3, 1'b0, 1'b0, 1'b1, eq, er);
      chk("u_uns", "R1", int'(q_u), eq, int'(r_u), er);
      #1 aclr = 1'b1;
      #1;
      chk("uut",   "R8 async", int'(q_a), 0, int'(r_a), 0);
      chk("u_uns", "R8 async", int'(q_u), 0, int'(r_u), 0);
      chk("u_mix", "R8 async", int'(q_m), 0, int'(r_m), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: expired, expected run to end");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule